// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder

This block produces the active-low chip selects for an 8-bit controller whose code and data live in separate 64 KB address spaces. A code-fetch strobe marks code-space cycles, and read and write strobes mark data-space cycles. The lower half of each space has a fixed owner. A secondary flash answers code fetches there, and an internal SRAM answers data accesses. Who owns the upper half depends on two small registers that the CPU writes through a register port.

The page register picks one of eight 32 KB main flash sectors for the upper window. It also picks one of two external SRAM banks. A single mode bit moves main flash out of code space and into the upper data window. The external SRAM selects are then kept off, so flash and SRAM can never both drive the upper data window. The select logic is combinational on the address, the strobes and the register contents. A register write therefore changes decoding from the cycle after its clock edge.

Top module: `paged_cs_decode`

## Requirements
- R1: After reset the page register reads 0x00 and the mode register reads 0x00, which means main flash is in code space.
- R2: On a rising clock edge with reg_we_i high, the register named by reg_addr_i takes reg_wdata_i. Address 0 is the page register (8 bits). Address 1 is the mode register, where only bit 0 (flash-in-data) is stored and bits 7:1 read 0. reg_rdata_o shows the register named by reg_addr_i.
- R3: A code fetch to an address below 0x8000 drives sflash_cs_no low, whatever the page or mode.
- R4: With mode bit 0 clear, a code fetch at or above 0x8000 drives mflash_cs_no[page[2:0]] low if page bits 6:3 are zero (pages 0–7 and 128–135). For any other page no select goes low.
- R5: With mode bit 0 set, a data read or write at or above 0x8000 selects the main flash sector by the rule in R4, and both external SRAM selects stay high. Code fetches at or above 0x8000 then select nothing.
- R6: A data read or write below 0x8000 drives iram_cs_no low.
- R7: With mode bit 0 clear, a data read or write at or above 0x8000 drives xram_a_cs_no low when page bit 7 is 0 and xram_b_cs_no low when it is 1.
- R8: With no strobe active, all selects are high. When fetch_i is high, the cycle is a code cycle and rd_i and wr_i are ignored.
- R9: At most one of the twelve select outputs is low in any cycle.
- R10: In a cycle that writes a register, decoding uses the old register value. The new value takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| fetch_i | input | 1 | Code-fetch strobe, active high |
| rd_i | input | 1 | Data read strobe, active high |
| wr_i | input | 1 | Data write strobe, active high |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 1 | Register select: 0 page, 1 mode |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| mflash_cs_no | output | 8 | Main flash sector selects, active low |
| sflash_cs_no | output | 1 | Secondary flash select, active low |
| iram_cs_no | output | 1 | Internal SRAM select, active low |
| xram_a_cs_no | output | 1 | External SRAM bank A select, active low |
| xram_b_cs_no | output | 1 | External SRAM bank B select, active low |

## Verification
A register write and an address decode can fall in the same cycle. The bench provokes this by raising reg_we_i with a new page or mode value while a fetch or data strobe targets the upper window. It expects the selects of that cycle to follow the old register value and the next cycle's selects to follow the new one. A second overlap is a fetch that is raised together with a data strobe. The bench judges it by requiring a code-space select only. A sweep over every page value, both modes and all strobe combinations checks the full select vector and that no two selects are low together.

// File: rtl/paged_cs_pkg.sv
`timescale 1ns/1ps
package paged_cs_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SECTORS = 8;

  typedef enum logic {
    REG_PAGE = 1'b0,
    REG_MODE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/page_regs.sv
`timescale 1ns/1ps
module page_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] page_o,
  output logic              flash_data_o
);
  import paged_cs_pkg::*;

  logic [DATA_W-1:0] page_q;
  logic              mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      mode_q <= 1'b0;
    end else if (we_i) begin
      if (reg_sel_e'(addr_i) == REG_PAGE) page_q <= wdata_i;
      else                                mode_q <= wdata_i[0];
    end
  end

  always_comb begin
    if (reg_sel_e'(addr_i) == REG_PAGE) rdata_o = page_q;
    else                                rdata_o = {{(DATA_W-1){1'b0}}, mode_q};
  end

  assign page_o       = page_q;
  assign flash_data_o = mode_q;
endmodule

// File: rtl/cs_decode.sv
`timescale 1ns/1ps
module cs_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned SECTORS  = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fetch_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              flash_data_i,
  output logic [SECTORS-1:0] mflash_cs_no,
  output logic              sflash_cs_no,
  output logic              iram_cs_no,
  output logic              xram_a_cs_no,
  output logic              xram_b_cs_no
);
  localparam int unsigned SEC_W = $clog2(SECTORS);

  logic upper, code_cyc, data_cyc, page_ok, flash_win;
  logic [SEC_W-1:0] sector;

  assign upper    = (addr_i >= WIN_BASE);
  assign code_cyc = fetch_i;
  // fetch wins over data strobes
  assign data_cyc = !fetch_i && (rd_i || wr_i);
  // top page bit picks the SRAM bank; bits between it and the sector field must be zero
  assign page_ok  = (page_i[PAGE_W-2:SEC_W] == '0);
  assign sector   = page_i[SEC_W-1:0];

  assign flash_win = upper && page_ok &&
                     (flash_data_i ? data_cyc : code_cyc);

  for (genvar s = 0; s < SECTORS; s++) begin : g_sec
    assign mflash_cs_no[s] = !(flash_win && (sector == SEC_W'(s)));
  end

  assign sflash_cs_no = !(code_cyc && !upper);
  assign iram_cs_no   = !(data_cyc && !upper);
  assign xram_a_cs_no = !(data_cyc && upper && !flash_data_i && !page_i[PAGE_W-1]);
  assign xram_b_cs_no = !(data_cyc && upper && !flash_data_i &&  page_i[PAGE_W-1]);
endmodule

// File: rtl/paged_cs_decode.sv
`timescale 1ns/1ps
module paged_cs_decode
  import paged_cs_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = SECTORS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          fetch_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic [NS-1:0] mflash_cs_no,
  output logic          sflash_cs_no,
  output logic          iram_cs_no,
  output logic          xram_a_cs_no,
  output logic          xram_b_cs_no
);
  logic [DW-1:0] page_q;
  logic          mode_q;

  page_regs #(.DATA_W(DW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .page_o       (page_q),
    .flash_data_o (mode_q)
  );

  cs_decode #(
    .ADDR_W   (AW),
    .PAGE_W   (DW),
    .SECTORS  (NS),
    .WIN_BASE (AW'(1) << (AW-1))
  ) u_dec (
    .addr_i       (addr_i),
    .fetch_i      (fetch_i),
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .page_i       (page_q),
    .flash_data_i (mode_q),
    .mflash_cs_no (mflash_cs_no),
    .sflash_cs_no (sflash_cs_no),
    .iram_cs_no   (iram_cs_no),
    .xram_a_cs_no (xram_a_cs_no),
    .xram_b_cs_no (xram_b_cs_no)
  );
endmodule

// File: rtl/paged_cs_checker.sv
`timescale 1ns/1ps
module paged_cs_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned NS = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          fetch_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          reg_we_i,
  input logic          reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] page_q,
  input logic [NS-1:0] mflash_cs_no,
  input logic          sflash_cs_no,
  input logic          iram_cs_no,
  input logic          xram_a_cs_no,
  input logic          xram_b_cs_no
);
  logic [NS+3:0] cs_low;
  assign cs_low = ~{mflash_cs_no, sflash_cs_no, iram_cs_no, xram_a_cs_no, xram_b_cs_no};

  p_one_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_low));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_i && !rd_i && !wr_i) |-> (cs_low == '0));

  p_fetch_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |-> (iram_cs_no && xram_a_cs_no && xram_b_cs_no));

  p_sflash_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && !addr_i[AW-1]) |-> !sflash_cs_no);

  p_iram_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_i && (rd_i || wr_i) && !addr_i[AW-1]) |-> !iram_cs_no);

  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&mflash_cs_no) |-> (xram_a_cs_no && xram_b_cs_no));

  p_page_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i) |=> (page_q == $past(reg_wdata_i)));
endmodule

bind paged_cs_decode paged_cs_checker #(.AW(AW), .DW(DW), .NS(NS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .fetch_i      (fetch_i),
  .rd_i         (rd_i),
  .wr_i         (wr_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .page_q       (page_q),
  .mflash_cs_no (mflash_cs_no),
  .sflash_cs_no (sflash_cs_no),
  .iram_cs_no   (iram_cs_no),
  .xram_a_cs_no (xram_a_cs_no),
  .xram_b_cs_no (xram_b_cs_no)
);

// File: tb/paged_cs_decode_test.sv
`timescale 1ns/1ps
module paged_cs_decode_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        fetch = 0, rd = 0, wr = 0;
  logic        reg_we = 0, reg_addr = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  mcs;
  logic        scs, ics, xa, xb;

  int total = 0, bad = 0;
  bit done = 0;

  // model state, tracked from writes only
  logic [7:0] m_page = 8'h00;
  logic       m_mode = 1'b0;

  logic [11:0] q_cs[$];
  logic [7:0]  q_rd[$];
  string       q_tag[$];

  always #4 clk = ~clk;  // 125 MHz

  paged_cs_decode uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .fetch_i(fetch), .rd_i(rd), .wr_i(wr),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mflash_cs_no(mcs), .sflash_cs_no(scs), .iram_cs_no(ics),
    .xram_a_cs_no(xa), .xram_b_cs_no(xb)
  );

  // vector order {mflash[7:0], sflash, iram, xram_a, xram_b}, active low
  function automatic logic [11:0] exp_cs(logic [15:0] a, logic f, logic r, logic w,
                                         logic [7:0] pg, logic md);
    logic [11:0] v = '1;
    logic hi = a[15];
    logic dc = !f && (r || w);
    logic ok = (pg[6:3] == 4'd0);
    if (f && !hi) v[3] = 1'b0;
    if (dc && !hi) v[2] = 1'b0;
    if (f && hi && !md && ok) v[4 + pg[2:0]] = 1'b0;
    if (dc && hi && md && ok) v[4 + pg[2:0]] = 1'b0;
    if (dc && hi && !md) begin
      if (pg[7]) v[0] = 1'b0; else v[1] = 1'b0;
    end
    return v;
  endfunction

  task automatic apply(input logic [15:0] a, input logic f, input logic r, input logic w,
                       input logic we, input logic ra, input logic [7:0] wd, input string tag);
    @(negedge clk);
    addr = a; fetch = f; rd = r; wr = w;
    reg_we = we; reg_addr = ra; reg_wdata = wd;
    q_cs.push_back(exp_cs(a, f, r, w, m_page, m_mode));
    q_rd.push_back(ra ? {7'd0, m_mode} : m_page);
    q_tag.push_back(tag);
    if (we) begin
      if (ra) m_mode = wd[0]; else m_page = wd;
    end
  endtask

  task automatic set_regs(input logic [7:0] pg, input logic md);
    apply(16'h0000, 0, 0, 0, 1, 0, pg, "R2");
    apply(16'h0000, 0, 0, 0, 1, 1, {7'h55, md}, "R2");
  endtask

  // monitor: sample 2 ns after the negedge the driver used
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q_cs.size() > 0) begin
        logic [11:0] ec, ac;
        logic [7:0]  er;
        string t;
        ec = q_cs.pop_front(); er = q_rd.pop_front(); t = q_tag.pop_front();
        ac = {mcs, scs, ics, xa, xb};
        total++;
        if (ac !== ec) begin
          bad++;
          $display("FAIL %s cs actual=%b expected=%b", t, ac, ec);
        end
        total++;
        if (reg_rdata !== er) begin
          bad++;
          $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata, er);
        end
        total++;
        if ($countones(~ac) > 1) begin
          bad++;
          $display("FAIL R9 lows actual=%0d expected<=1", $countones(~ac));
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while held in reset
    total++;
    if (reg_rdata !== 8'h00) begin bad++; $display("FAIL R1 page actual=%h expected=00", reg_rdata); end
    reg_addr = 1; #1;
    total++;
    if (reg_rdata !== 8'h00) begin bad++; $display("FAIL R1 mode actual=%h expected=00", reg_rdata); end
    reg_addr = 0;
    @(negedge clk); rst_ni = 1'b1;

    apply(16'h0000, 0, 0, 0, 0, 1, 8'h00, "R1");
    apply(16'h1234, 1, 0, 0, 0, 0, 8'h00, "R3");
    apply(16'hC000, 1, 0, 0, 0, 0, 8'h00, "R4");
    apply(16'h7FFF, 0, 1, 0, 0, 0, 8'h00, "R6");
    apply(16'h8000, 0, 0, 1, 0, 0, 8'h00, "R7");
    apply(16'hFFFF, 0, 0, 0, 0, 0, 8'h00, "R8");
    apply(16'h9000, 1, 1, 1, 0, 0, 8'h00, "R8");
    apply(16'h2000, 1, 0, 1, 0, 0, 8'h00, "R8");

    // R2: mode readback drops upper bits
    apply(16'h0000, 0, 0, 0, 1, 1, 8'hFF, "R2");
    apply(16'h0000, 0, 0, 0, 0, 1, 8'h00, "R2");
    apply(16'h8800, 0, 1, 0, 0, 0, 8'h00, "R5");
    apply(16'h8800, 1, 0, 0, 0, 0, 8'h00, "R5");

    // R10: write page in the same cycle as an upper data read
    apply(16'hA000, 0, 1, 0, 1, 0, 8'h05, "R10");
    apply(16'hA000, 0, 1, 0, 0, 0, 8'h00, "R10");
    // R10: mode cleared in the same cycle as an upper fetch
    apply(16'hA000, 1, 0, 0, 1, 1, 8'h00, "R10");
    apply(16'hA000, 1, 0, 0, 0, 1, 8'h00, "R10");
    apply(16'hE000, 0, 0, 1, 1, 0, 8'h83, "R10");
    apply(16'hE000, 0, 0, 1, 0, 0, 8'h00, "R7");
    apply(16'hE000, 1, 0, 0, 0, 0, 8'h00, "R4");
    apply(16'hF000, 1, 0, 0, 1, 0, 8'h40, "R10");
    apply(16'hF000, 1, 0, 0, 0, 0, 8'h00, "R4");

    // R9 sweep: every page, both modes, all strobe patterns, both halves
    for (int p = 0; p < 256; p++) begin
      for (int md = 0; md < 2; md++) begin
        set_regs(8'(p), md[0]);
        for (int s = 0; s < 8; s++) begin
          apply(16'h3A5C, s[2], s[1], s[0], 0, 0, 8'h00, "R9");
          apply(16'hB7E1, s[2], s[1], s[0], 0, 1, 8'h00, "R9");
        end
      end
    end

    @(negedge clk);
    @(negedge clk);
    #3;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule